// File: doc/BRIEF.md
# Receive Control-Word Checker for a 16-bit Packet Interface

This block watches a received stream of 16-bit words, each tagged as either a control word or a data word, and turns it into a clean per-word output with packet framing attached. Every control word is split into its fields: a payload/idle type bit, a two-bit end-of-packet code that closes the burst just received, a start-of-packet flag and an eight-bit port address. A four-bit diagonal parity is recomputed over each control word and the data words that came before it, and protocol misuse is reported on single-cycle error strobes.

The end-of-packet code for a burst only arrives in the control word after that burst. For this reason every data word is held back by one word time. When the next word shows up, the held word is released, and if that next word is a control word, the end-of-packet marking and the valid-byte count are attached to it on the way out. The block is a monitor: it never stalls the stream and keeps no packet storage beyond the single held word.

Top module: `rx_ctlword_chk`

## Requirements
- R1: After reset, `out_valid`, `out_sop`, `out_eop`, `out_abort`, `out_bytes` and all five error strobes are 0.
- R2: An accepted data word appears on `out_data` with `out_valid` high in the cycle after the next accepted word, whether that word is data or control. It carries in `out_port` the address bits 11:4 of the payload control word that opened its burst. `out_sop` is 1 only on the first word after a payload control word that had bit 12 set.
- R3: A control word that follows one or more data words closes that burst. Its bits 14:13 mark the released word: 00 gives no EOP and `out_bytes`=2; 01 gives EOP with `out_abort`; 10 gives EOP with `out_bytes`=2; 11 gives EOP with `out_bytes`=1.
- R4: The parity rule runs as follows. A 16-bit accumulator is cleared after each control word. For every later word, the accumulator is rotated left by one bit and XORed with that word; for the control word, bits 3:0 are replaced by 1111 first. The four nibbles of the result are XORed together and inverted. `err_dip` pulses when this value differs from the control word's bits 3:0.
- R5: `err_len` pulses when a control word with code 00 closes a burst whose word count is not a multiple of `BURST_WORDS` (8, i.e. 16 bytes).
- R6: `err_fmt` pulses for a control word with bit 15 clear that has bit 12 set, or whose address field is neither 0x00 (idle) nor 0xFF (training).
- R7: `err_seq` pulses for a control word with a nonzero code in bits 14:13 that closes no burst. It also pulses for a data word that arrives while the latest control word had bit 15 clear; such a data word is dropped and never appears on the output.
- R8: `err_pad` pulses when code 11 closes a burst whose last word has a nonzero low byte (bits 7:0).
- R9: Cycles with `in_valid` low change nothing: they produce no output and no strobe, and they do not disturb parity, hold or burst state.
- R10: Each error strobe is high for exactly the one cycle after the offending word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word present this cycle |
| in_ctl | input | 1 | 1 = control word, 0 = data word |
| in_word | input | 16 | Received word |
| out_valid | output | 1 | Released data word valid |
| out_data | output | 16 | Released data word |
| out_port | output | 8 | Port of the released word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_abort | output | 1 | Packet ended by abort |
| out_bytes | output | 2 | Valid bytes in the released word (1 or 2) |
| err_dip | output | 1 | Parity mismatch strobe |
| err_len | output | 1 | Non-EOP burst length strobe |
| err_fmt | output | 1 | Malformed idle/training word strobe |
| err_seq | output | 1 | Sequencing violation strobe |
| err_pad | output | 1 | Nonzero pad byte strobe |

## Verification
A single closing control word does two jobs in the same cycle: it releases the held last word with its end-of-packet marking, and it is also judged by the parity, length and pad checks. The bench sends closing words with a deliberately corrupted parity field, bursts that end with code 00 at a length that is not a multiple of eight words, and one-byte endings with a dirty low byte. It then expects the EOP-marked data word and the error strobe to appear together in the following cycle. A behavioural model built on queues gives the expected value of every output on every cycle, and the bench compares the two.

// File: rtl/rx_ctlword_chk.sv
module rx_ctlword_chk #(
  parameter int BURST_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_ctl,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic [7:0]  out_port,
  output logic        out_sop,
  output logic        out_eop,
  output logic        out_abort,
  output logic [1:0]  out_bytes,
  output logic        err_dip,
  output logic        err_len,
  output logic        err_fmt,
  output logic        err_seq,
  output logic        err_pad
);
  localparam int CNTW = $clog2(BURST_WORDS) + 1;

  logic [15:0]     acc, hold_d;
  logic [7:0]      hold_p, cur_port;
  logic            hold_v, hold_s, in_pay, next_sop;
  logic [CNTW-1:0] cnt;

  wire        is_d = in_valid & ~in_ctl;
  wire        is_c = in_valid & in_ctl;
  wire [15:0] mix  = {acc[14:0], acc[15]} ^ (in_ctl ? {in_word[15:4], 4'hF} : in_word);
  wire [3:0]  dip  = ~(mix[15:12] ^ mix[11:8] ^ mix[7:4] ^ mix[3:0]);
  wire [1:0]  code = in_word[14:13];
  wire [7:0]  adr  = in_word[11:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; hold_d <= '0; hold_p <= '0; hold_v <= 1'b0; hold_s <= 1'b0;
      cur_port <= '0; in_pay <= 1'b0; next_sop <= 1'b0; cnt <= '0;
      out_valid <= 1'b0; out_data <= '0; out_port <= '0; out_sop <= 1'b0;
      out_eop <= 1'b0; out_abort <= 1'b0; out_bytes <= '0;
      err_dip <= 1'b0; err_len <= 1'b0; err_fmt <= 1'b0; err_seq <= 1'b0; err_pad <= 1'b0;
    end else begin
      out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0; out_abort <= 1'b0; out_bytes <= '0;
      err_dip <= 1'b0; err_len <= 1'b0; err_fmt <= 1'b0; err_seq <= 1'b0; err_pad <= 1'b0;
      if (is_d) begin
        acc <= mix;
        if (!in_pay) begin
          err_seq <= 1'b1;
        end else begin
          if (hold_v) begin
            out_valid <= 1'b1; out_data <= hold_d; out_port <= hold_p;
            out_sop <= hold_s; out_bytes <= 2'd2;
          end
          hold_v <= 1'b1; hold_d <= in_word; hold_p <= cur_port; hold_s <= next_sop;
          next_sop <= 1'b0;
          cnt <= (cnt == CNTW'(BURST_WORDS - 1)) ? '0 : cnt + 1'b1;
        end
      end else if (is_c) begin
        acc <= '0;
        cnt <= '0;
        hold_v <= 1'b0;
        err_dip <= (dip != in_word[3:0]);
        if (hold_v) begin
          out_valid <= 1'b1; out_data <= hold_d; out_port <= hold_p; out_sop <= hold_s;
          out_eop   <= (code != 2'b00);
          out_abort <= (code == 2'b01);
          out_bytes <= (code == 2'b11) ? 2'd1 : 2'd2;
          err_len   <= (code == 2'b00) && (cnt != '0);
          err_pad   <= (code == 2'b11) && (hold_d[7:0] != 8'h00);
        end else begin
          err_seq <= (code != 2'b00);
        end
        in_pay <= in_word[15];
        if (in_word[15]) begin
          cur_port <= adr;
          next_sop <= in_word[12];
        end else begin
          next_sop <= 1'b0;
          err_fmt  <= in_word[12] || !(adr == 8'h00 || adr == 8'hFF);
        end
      end
    end
  end
endmodule

module rx_ctlword_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ctl,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic        out_eop,
  input logic        out_abort,
  input logic [1:0]  out_bytes,
  input logic        err_len,
  input logic        err_seq,
  input logic        err_pad
);
  a_r2_out_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  a_r3_eop_from_control: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> (out_valid && $past(in_valid && in_ctl)));
  a_r3_abort_is_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> out_eop);
  a_r3_one_byte_is_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_bytes == 2'd1) |-> out_eop);
  a_r8_pad_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    err_pad |-> (out_eop && out_bytes == 2'd1 && out_data[7:0] != 8'h00));
  a_r5_len_excludes_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_len, err_seq}));
  a_r9_no_output_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !(out_valid || err_seq || err_len || err_pad));
endmodule

bind rx_ctlword_chk rx_ctlword_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl),
  .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
  .out_abort(out_abort), .out_bytes(out_bytes), .err_len(err_len),
  .err_seq(err_seq), .err_pad(err_pad)
);

// File: tb/tb_rx_ctlword_chk.sv
module tb_rx_ctlword_chk;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_ctl = 1'b0;
  logic [15:0] in_word = '0;
  logic out_valid, out_sop, out_eop, out_abort, err_dip, err_len, err_fmt, err_seq, err_pad;
  logic [15:0] out_data;
  logic [7:0] out_port;
  logic [1:0] out_bytes;

  always #4 clk = ~clk;

  rx_ctlword_chk dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] pw[$];
  logic [15:0] bq[$];
  logic [7:0]  pq[$];
  bit          sq[$];
  bit          m_pay = 0, m_sop = 0;
  logic [7:0]  m_port = 0;

  logic        e_valid, e_sop, e_eop, e_abort, e_dip, e_len, e_fmt, e_seq, e_pad;
  logic [15:0] e_data;
  logic [7:0]  e_port;
  logic [1:0]  e_bytes;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] calc_dip(input logic [15:0] cw);
    logic [15:0] a = '0;
    int n = pw.size() + 1;
    for (int i = 0; i < n; i++) begin
      logic [15:0] w = (i < n - 1) ? pw[i] : {cw[15:4], 4'hF};
      int r = n - 1 - i;
      for (int b = 0; b < 16; b++) a[(b + r) % 16] ^= w[b];
    end
    return ~(a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12]);
  endfunction

  task automatic step(input bit v, input bit c, input logic [15:0] w, input string vtag);
    e_valid = 0; e_sop = 0; e_eop = 0; e_abort = 0; e_bytes = 0;
    e_dip = 0; e_len = 0; e_fmt = 0; e_seq = 0; e_pad = 0; e_data = 0; e_port = 0;
    if (v && !c) begin
      pw.push_back(w);
      if (!m_pay) e_seq = 1;
      else begin
        if (bq.size() > 0) begin
          e_valid = 1; e_data = bq[$]; e_port = pq[$]; e_sop = sq[$]; e_bytes = 2;
        end
        bq.push_back(w); pq.push_back(m_port); sq.push_back(m_sop); m_sop = 0;
      end
    end else if (v && c) begin
      e_dip = (calc_dip(w) != w[3:0]);
      if (bq.size() > 0) begin
        e_valid = 1; e_data = bq[$]; e_port = pq[$]; e_sop = sq[$];
        e_eop = (w[14:13] != 0); e_abort = (w[14:13] == 1);
        e_bytes = (w[14:13] == 3) ? 1 : 2;
        e_len = (w[14:13] == 0) && (bq.size() % 8 != 0);
        e_pad = (w[14:13] == 3) && (bq[$][7:0] != 0);
      end else e_seq = (w[14:13] != 0);
      bq.delete(); pq.delete(); sq.delete(); pw.delete();
      m_pay = w[15];
      if (w[15]) begin m_port = w[11:4]; m_sop = w[12]; end
      else begin
        m_sop = 0;
        e_fmt = w[12] || !(w[11:4] == 8'h00 || w[11:4] == 8'hFF);
      end
    end
    in_valid = v; in_ctl = c; in_word = w;
    @(negedge clk);
    chk({vtag, " valid"}, out_valid, e_valid);
    if (e_valid) begin
      chk("R2 data", out_data, e_data);
      chk("R2 port", out_port, e_port);
      chk("R2 sop", out_sop, e_sop);
    end
    chk("R3 eop", out_eop, e_eop);
    chk("R3 abort", out_abort, e_abort);
    chk("R3 bytes", out_bytes, e_bytes);
    chk("R4/R10 dip", err_dip, e_dip);
    chk("R5/R10 len", err_len, e_len);
    chk("R6/R10 fmt", err_fmt, e_fmt);
    chk("R7/R10 seq", err_seq, e_seq);
    chk("R8/R10 pad", err_pad, e_pad);
  endtask

  task automatic ctl(input bit t, input logic [1:0] code, input bit sop, input logic [7:0] adr,
                     input bit bad);
    logic [15:0] w = {t, code, sop, adr, 4'h0};
    w[3:0] = calc_dip(w) ^ (bad ? 4'h1 : 4'h0);
    step(1, 1, w, "R2");
  endtask

  task automatic dat(input logic [15:0] w);
    step(1, 0, w, "R2");
  endtask

  task automatic gap();
    step(0, 1, 16'hE5A3, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", out_valid, 0); chk("R1 sop", out_sop, 0); chk("R1 eop", out_eop, 0);
    chk("R1 abort", out_abort, 0); chk("R1 bytes", out_bytes, 0);
    chk("R1 errs", {err_dip, err_len, err_fmt, err_seq, err_pad}, 0);
    rst_n = 1;
    ctl(0, 0, 0, 8'hFF, 0);
    ctl(0, 0, 0, 8'h00, 0);
    ctl(1, 0, 1, 8'h12, 0);
    for (int i = 0; i < 8; i++) dat(16'h1000 + 16'(i * 37));
    ctl(1, 0, 0, 8'h12, 0);
    for (int i = 0; i < 3; i++) dat(16'hA5C0 ^ 16'(i));
    ctl(0, 2, 0, 8'h00, 0);
    ctl(1, 0, 1, 8'h34, 0);
    dat(16'hBEEF); gap(); dat(16'h7700); gap(); gap();
    ctl(0, 3, 0, 8'h00, 0);
    ctl(1, 0, 1, 8'h56, 0); dat(16'h1111); dat(16'h22AB);
    ctl(0, 3, 0, 8'h00, 0);
    ctl(1, 0, 1, 8'h9A, 0); dat(16'h3333); dat(16'h4444);
    ctl(1, 1, 1, 8'h9B, 0);
    dat(16'h5555); dat(16'h6666); dat(16'h7777);
    ctl(1, 0, 0, 8'h9B, 0);
    dat(16'h8888); dat(16'h9999);
    ctl(0, 2, 0, 8'hFF, 1);
    ctl(0, 0, 0, 8'h05, 0);
    ctl(0, 0, 1, 8'h00, 0);
    ctl(0, 2, 0, 8'h00, 0);
    dat(16'hDEAD);
    ctl(0, 0, 0, 8'h00, 0);
    ctl(1, 0, 1, 8'hC3, 0);
    for (int i = 0; i < 16; i++) begin dat(16'hF000 | 16'(i)); if (i == 5) gap(); end
    ctl(1, 0, 0, 8'hC3, 1);
    dat(16'h0F0F);
    ctl(0, 1, 0, 8'h00, 0);
    gap(); gap();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule